// File: doc/BRIEF.md
# Configurable External Interrupt Condition Detector

This block turns eight raw external interrupt pins into request flags for the downstream priority logic. Each pin is first brought into the clock domain through a two-stage synchroniser. It is then checked against an active condition chosen for that pin alone: high level, low level, rising edge or falling edge.

In the two level conditions the request follows the synchronised pin and is never stored. It drops only when the external source releases the pin. In the two edge conditions a detected edge sets a sticky flag. The flag stays set until software writes a one to that pin's bit in the clear register. A simple write port with one address bit selects between the condition register and the clear register.

Top module: `ext_irq_cond`

## Requirements
- R1: While `rst_n` is low and right after its release, `irq_req` is all zero, every pin's condition is high level and every stored edge flag is clear.
- R2: A write with `wr_addr` = 0 loads the condition register from `wr_data`. Pin i takes bits [2i+1:2i], encoded 00 = high level, 01 = low level, 10 = rising edge, 11 = falling edge. Each pin follows its own code independently of the others.
- R3: In high-level condition, `irq_req[i]` equals the value `irq_pin[i]` had two clock edges earlier, counting the two synchroniser stages.
- R4: In low-level condition, `irq_req[i]` equals the inverse of the value `irq_pin[i]` had two clock edges earlier.
- R5: In rising-edge condition, a 0-to-1 change of the synchronised pin sets `irq_req[i]` on the third clock edge after the pin changes. The request then stays high whatever the pin does until it is cleared.
- R6: In falling-edge condition, a 1-to-0 change of the synchronised pin sets `irq_req[i]` with the same latency as R5 and holds it in the same way.
- R7: A write with `wr_addr` = 1 clears the stored edge flag of every pin whose bit i of `wr_data` is one. Bits that are zero leave their flag unchanged.
- R8: A clear write to a pin in a level condition has no effect; its request keeps following the pin.
- R9: When a new edge is detected in the same cycle as a clear write to that pin, the flag stays set.
- R10: Writing a different condition code to a pin clears its stored edge flag, even if an edge is detected in that cycle. Rewriting the same code leaves the flag intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pin | input | 8 | Raw external interrupt pins, asynchronous |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 1 | 0 = condition register, 1 = clear register |
| wr_data | input | 16 | Write data; the clear register uses bits [7:0] |
| irq_req | output | 8 | Request flags to the priority logic |

## Verification
The hardest case to reach from the ports is a clear write landing in exactly the cycle in which a freshly synchronised edge is detected. That cycle lies two edges after the pin moves and cannot be seen at the outputs. The stimulus changes a pin on a falling clock edge, waits two falling edges, and then holds the clear strobe for one cycle, so that the write meets the detection. The same timing is used to land a condition change on a detected edge. A cycle-accurate reference model compares every output bit on every clock, so an off-by-one in either race shows up at once.

// File: rtl/ext_irq_cond.sv
module ext_irq_cond #(
  parameter int N_PINS = 8,
  localparam int MODE_W = 2,
  localparam int DATA_W = N_PINS * MODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] irq_pin,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [N_PINS-1:0] irq_req
);

  logic [N_PINS-1:0] sync1, sync2, sync_d;
  logic [DATA_W-1:0] mode_q;
  logic [N_PINS-1:0] flag_q;
  logic [N_PINS-1:0] edge_hit;

  wire mode_wr = wr_en & ~wr_addr;
  wire clr_wr  = wr_en &  wr_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1  <= '0;
      sync2  <= '0;
      sync_d <= '0;
    end else begin
      sync1  <= irq_pin;
      sync2  <= sync1;
      sync_d <= sync2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= '0;
    else if (mode_wr) mode_q <= wr_data;
  end

  for (genvar i = 0; i < N_PINS; i++) begin : g_pin
    wire [MODE_W-1:0] cur = mode_q[MODE_W*i +: MODE_W];
    wire [MODE_W-1:0] nxt = wr_data[MODE_W*i +: MODE_W];
    wire is_edge = cur[1];
    wire rise = sync2[i] & ~sync_d[i];
    wire fall = ~sync2[i] & sync_d[i];

    assign edge_hit[i] = is_edge & (cur[0] ? fall : rise);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          flag_q[i] <= 1'b0;
      else if (mode_wr && nxt != cur)      flag_q[i] <= 1'b0;
      else if (!is_edge)                   flag_q[i] <= 1'b0;
      else if (edge_hit[i])                flag_q[i] <= 1'b1;
      else if (clr_wr && wr_data[i])       flag_q[i] <= 1'b0;
    end

    assign irq_req[i] = is_edge ? flag_q[i] : (sync2[i] ^ cur[0]);
  end

endmodule

// File: rtl/ext_irq_cond_chk.sv
module ext_irq_cond_chk #(
  parameter int N_PINS = 8,
  localparam int DATA_W = N_PINS * 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_PINS-1:0] irq_pin,
  input logic              wr_en,
  input logic              wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [N_PINS-1:0] irq_req,
  input logic [DATA_W-1:0] mode_q,
  input logic [N_PINS-1:0] edge_hit
);

  logic [1:0] up_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             up_cnt <= '0;
    else if (up_cnt != 2'd3) up_cnt <= up_cnt + 2'd1;
  end

  for (genvar i = 0; i < N_PINS; i++) begin : g_chk
    wire [1:0] md = mode_q[2*i +: 2];

    // R3
    high_level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (up_cnt >= 2'd2 && md == 2'b00) |-> irq_req[i] == $past(irq_pin[i], 2));

    // R4
    low_level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (up_cnt >= 2'd2 && md == 2'b01) |-> irq_req[i] == !$past(irq_pin[i], 2));

    // R5
    edge_flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (md[1] && irq_req[i] && !wr_en) |=> irq_req[i]);

    // R7
    clear_drops_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (md[1] && wr_en && wr_addr && wr_data[i] && !edge_hit[i]) |=> !irq_req[i]);

    // R9
    edge_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_hit[i] && !(wr_en && !wr_addr)) |=> irq_req[i]);

    // R10
    mode_change_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_addr && wr_data[2*i+1] && wr_data[2*i +: 2] != md) |=> !irq_req[i]);
  end

endmodule

bind ext_irq_cond ext_irq_cond_chk #(.N_PINS(N_PINS)) chk_i (
  .clk(clk), .rst_n(rst_n), .irq_pin(irq_pin), .wr_en(wr_en),
  .wr_addr(wr_addr), .wr_data(wr_data), .irq_req(irq_req),
  .mode_q(mode_q), .edge_hit(edge_hit)
);

// File: tb/ext_irq_cond_tb_top.sv
module ext_irq_cond_tb_top;
  localparam int N = 8;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [N-1:0] irq_pin = '0;
  logic        wr_en = 0;
  logic        wr_addr = 0;
  logic [2*N-1:0] wr_data = '0;
  logic [N-1:0] irq_req;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 0;
  string phase = "R1";

  ext_irq_cond #(.N_PINS(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .irq_pin(irq_pin), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .irq_req(irq_req)
  );

  always #10 clk = ~clk;

  // behavioural reference
  logic [N-1:0] hist[$];
  int md[N];
  bit flag[N];
  logic [N-1:0] exp_req;

  function automatic logic [N-1:0] model_out();
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) begin
      if (md[i] < 2) r[i] = hist[1][i] ^ md[i][0];
      else           r[i] = flag[i];
    end
    return r;
  endfunction

  initial begin
    hist = '{'0, '0, '0};
    for (int i = 0; i < N; i++) begin md[i] = 0; flag[i] = 0; end
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist = '{'0, '0, '0};
      for (int i = 0; i < N; i++) begin md[i] = 0; flag[i] = 0; end
    end else begin
      for (int i = 0; i < N; i++) begin
        int nm;
        bit hit;
        nm = int'(wr_data[2*i +: 2]);
        hit = (md[i] == 2 && hist[1][i] && !hist[2][i]) ||
              (md[i] == 3 && !hist[1][i] && hist[2][i]);
        if (wr_en && !wr_addr && nm != md[i]) flag[i] = 0;
        else if (md[i] < 2)                   flag[i] = 0;
        else if (hit)                         flag[i] = 1;
        else if (wr_en && wr_addr && wr_data[i]) flag[i] = 0;
      end
      if (wr_en && !wr_addr)
        for (int i = 0; i < N; i++) md[i] = int'(wr_data[2*i +: 2]);
      hist.push_front(irq_pin);
      void'(hist.pop_back());
    end
  end

  task automatic check(string req, logic [N-1:0] act, logic [N-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: irq_req=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      exp_req = model_out();
      check(phase, irq_req, exp_req);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write(logic a, logic [2*N-1:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0; wr_data = '0;
  endtask

  task automatic pins(logic [N-1:0] v);
    @(negedge clk);
    irq_pin = v;
    cyc(4);
  endtask

  initial begin
    logic [15:0] lf;
    cyc(3);
    check("R1", irq_req, '0);
    @(negedge clk) rst_n = 1;
    cyc(1);
    check("R1", irq_req, '0);

    phase = "R3";
    pins(8'hA5); check("R3", irq_req, 8'hA5);
    pins(8'h3C); pins(8'h00);

    phase = "R4";
    write(0, 16'h5555);
    pins(8'h0F); check("R4", irq_req, 8'hF0);
    pins(8'hFF);

    phase = "R5";
    write(0, 16'hAAAA);
    pins(8'h00);
    pins(8'h5A); check("R5", irq_req, 8'h5A);
    pins(8'h00); check("R5", irq_req, 8'h5A);

    phase = "R7";
    write(1, 16'h000F); cyc(1); check("R7", irq_req, 8'h50);
    write(1, 16'h0000); cyc(1); check("R7", irq_req, 8'h50);
    write(1, 16'h00FF);

    phase = "R6";
    write(0, 16'hFFFF);
    pins(8'hFF); check("R6", irq_req, 8'h00);
    pins(8'h33); check("R6", irq_req, 8'hCC);
    pins(8'hFF); check("R6", irq_req, 8'hCC);

    phase = "R8";
    write(0, 16'h0000);
    write(1, 16'h00FF); cyc(1); check("R8", irq_req, 8'hFF);
    pins(8'h00);

    phase = "R9";
    write(0, 16'hAAAA);
    @(negedge clk) irq_pin = 8'h01;
    cyc(1);
    @(negedge clk) begin wr_en = 1; wr_addr = 1; wr_data = 16'h0001; end
    @(negedge clk) begin wr_en = 0; wr_data = '0; end
    cyc(1); check("R9", irq_req, 8'h01);

    phase = "R10";
    write(0, 16'hAAAA); cyc(1); check("R10", irq_req, 8'h01);
    write(0, 16'hAAAB); cyc(1); check("R10", irq_req, 8'h00);
    write(0, 16'hAAAA);
    @(negedge clk) irq_pin = 8'h03;
    cyc(1);
    @(negedge clk) begin wr_en = 1; wr_addr = 0; wr_data = 16'hAAAB; end
    @(negedge clk) begin wr_en = 0; wr_data = '0; end
    cyc(1); check("R10", irq_req, 8'h02);

    phase = "R2";
    write(0, 16'hE4E4);
    pins(8'h00);
    pins(8'hFF); pins(8'h0F); pins(8'hF0);
    lf = 16'hACE1;
    for (int k = 0; k < 400; k++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      @(negedge clk);
      irq_pin = lf[7:0] ^ lf[15:8];
      wr_en = (lf[3:0] == 4'h5) || (lf[3:0] == 4'hA);
      wr_addr = lf[4];
      wr_data = {lf[7:0], lf[15:8]};
    end
    @(negedge clk) wr_en = 0;
    cyc(4);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule